// File: doc/BRIEF.md
# In-Order Issue Controller with Micro-op Carry-Over

This block decides, one clock cycle at a time, whether the instruction offered to an in-order pipeline leaves for execution now, waits, or is spread over several cycles. Each cycle starts with `ISSUE_W` micro-op slots. Any micro-ops still owed by an earlier oversized instruction take slots first. The offered instruction is then tested against the slots that remain and against its grouping flags. The bench then applies three stall sources in a fixed order: a register-dependency count, a busy execution resource, and a check that keeps result write-backs in program order.

Instructions arrive on a valid/ready stream, and a transfer happens in the cycle that both are high. The source must hold `in_uops`, the two group flags, `in_ooo_ret`, `in_wb_first` and `in_wb_last` steady from the first cycle `in_valid` rises until it sees `in_ready`, and must not drop `in_valid` in between. `in_reg_stall` and `in_res_busy` describe the state of the machine and may change in any cycle. `in_ready` is combinational from the inputs and the held state. An instruction that stalls is kept inside the block as held, and it is retried once its stall count runs out.

Top module: `ioi_issue_ctrl`

## Requirements
- R1: After synchronous reset, with `in_valid` low, `o_bw_left` equals `ISSUE_W`, `o_uops_used` is 0, and `in_ready`, `o_issue` and `o_stalled` are 0.
- R2: Every cycle starts with `ISSUE_W` free slots. An accepted instruction of n micro-ops (n of at least 1 and at most the free slots) raises `in_ready` and `o_issue` and leaves `o_bw_left` equal to the free slots minus n.
- R3: An instruction of more than `ISSUE_W` micro-ops is accepted whatever the free slots. It fills the free slots, and its remainder takes up to `ISSUE_W` slots in each later cycle. No instruction is accepted until the cycle in which the remainder ends, and in that cycle the unused slots are open to a new instruction.
- R4: An instruction of at most `ISSUE_W` micro-ops that needs more slots than are free is not accepted in that cycle.
- R5: A begin-group instruction is accepted only in a cycle in which no carried-over micro-ops were issued.
- R6: When an end-group instruction issues, or when the remainder of a carried-over end-group instruction ends, `o_bw_left` is 0 for that cycle.
- R7: The stall length is `in_reg_stall` if that is nonzero. Otherwise it is 1 if `in_res_busy` is high. Otherwise the write-back rule of R8 applies. A stalling cycle shows `o_bw_left` equal to 0 and no acceptance.
- R8: Unless `in_ooo_ret` is set, a candidate whose `in_wb_first` is below the pending last-write-back count stalls for the difference.
- R9: An issuing instruction without `in_ooo_ret` sets the last-write-back count to its `in_wb_last`. That count and the stall count each fall by one at the end of every cycle and stop at zero, so an instruction with `in_wb_first` 0 offered straight after one with `in_wb_last` of L issues L cycles after it.
- R10: A stalled instruction raises `o_stalled` from the next cycle on. While its stall count is nonzero, nothing issues and `o_bw_left` is 0. When the count reaches zero it is retried.
- R11: The micro-ops issued in one cycle (`o_uops_used`, carried plus new) never exceed `ISSUE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Candidate instruction present |
| in_ready | output | 1 | Candidate accepted (issues) this cycle |
| in_uops | input | UOP_W | Micro-op count, at least 1 |
| in_begin_grp | input | 1 | Must be first to issue in its cycle |
| in_end_grp | input | 1 | Closes the cycle's slots after it |
| in_ooo_ret | input | 1 | Exempt from write-back ordering |
| in_wb_first | input | CNT_W | Earliest result write-back delay |
| in_wb_last | input | CNT_W | Latest result write-back delay |
| in_reg_stall | input | CNT_W | Cycles until register operands are ready |
| in_res_busy | input | 1 | A needed execution resource is busy |
| o_issue | output | 1 | Issue pulse |
| o_bw_left | output | $clog2(ISSUE_W+1) | Slots left after this cycle's decisions |
| o_uops_used | output | $clog2(ISSUE_W+1) | Micro-ops issued this cycle |
| o_stalled | output | 1 | A stalled instruction is held |

## Verification
A directed sequence comes first. It sends an oversized instruction followed by one that cannot fit in the slots left. It sends an oversized end-group instruction followed by a small one. It sends a carry followed by a begin-group instruction. It sends register and resource stalls at the same time, and then a pair of writers where the second is marked non-ordered and another pair where it is not. These separate the carry, slot, group, priority and ordering rules, because each shows a different acceptance cycle. Random traffic from a fixed seed follows. It mixes sizes up to 7 micro-ops, both group flags, the retire flag, write-back spans and sporadic hazards. Every cycle is compared with a model of the requirements. A separate cycle count checks the last-write-back delay.

// File: rtl/ioi_pkg.sv
package ioi_pkg;
  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_REG  = 2'd1,
    HZ_RES  = 2'd2,
    HZ_WB   = 2'd3
  } hazard_e;
endpackage

// File: rtl/ioi_downcnt.sv
// Saturating down counter. A load stores the value already reduced by the
// end-of-cycle decrement of the loading cycle.
module ioi_downcnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/ioi_carry.sv
// Start-of-cycle slot accounting for micro-ops owed by a spilled instruction.
module ioi_carry #(
  parameter int ISSUE_W = 4,
  parameter int UOP_W   = 4,
  localparam int BW_W   = $clog2(ISSUE_W + 1)
) (
  input  logic [UOP_W-1:0] carry_left,
  input  logic             carry_eg,
  output logic [BW_W-1:0]  bw_after,
  output logic [BW_W-1:0]  used,
  output logic [UOP_W-1:0] left_next
);
  localparam logic [UOP_W-1:0] WIDE_U = UOP_W'(ISSUE_W);
  localparam logic [BW_W-1:0]  WIDE_B = BW_W'(ISSUE_W);

  always_comb begin
    if (carry_left == '0) begin
      bw_after  = WIDE_B;
      used      = '0;
      left_next = '0;
    end else if (carry_left > WIDE_U) begin
      bw_after  = '0;
      used      = WIDE_B;
      left_next = carry_left - WIDE_U;
    end else begin
      used      = BW_W'(carry_left);
      bw_after  = carry_eg ? '0 : WIDE_B - BW_W'(carry_left);
      left_next = '0;
    end
  end
endmodule

// File: rtl/ioi_hazard.sv
// Stall length for the candidate, in fixed priority order.
module ioi_hazard
  import ioi_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] reg_stall,
  input  logic             res_busy,
  input  logic             ooo_ret,
  input  logic [CNT_W-1:0] wb_first,
  input  logic [CNT_W-1:0] lwb_cur,
  output logic [CNT_W-1:0] stall_amt,
  output hazard_e          kind
);
  always_comb begin
    if (reg_stall != '0) begin
      stall_amt = reg_stall;
      kind      = HZ_REG;
    end else if (res_busy) begin
      stall_amt = CNT_W'(1);
      kind      = HZ_RES;
    end else if (!ooo_ret && (lwb_cur > wb_first)) begin
      stall_amt = lwb_cur - wb_first;
      kind      = HZ_WB;
    end else begin
      stall_amt = '0;
      kind      = HZ_NONE;
    end
  end
endmodule

// File: rtl/ioi_issue_ctrl.sv
module ioi_issue_ctrl
  import ioi_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int UOP_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [UOP_W-1:0]             in_uops,
  input  logic                         in_begin_grp,
  input  logic                         in_end_grp,
  input  logic                         in_ooo_ret,
  input  logic [CNT_W-1:0]             in_wb_first,
  input  logic [CNT_W-1:0]             in_wb_last,
  input  logic [CNT_W-1:0]             in_reg_stall,
  input  logic                         in_res_busy,
  output logic                         o_issue,
  output logic [$clog2(ISSUE_W+1)-1:0] o_bw_left,
  output logic [$clog2(ISSUE_W+1)-1:0] o_uops_used,
  output logic                         o_stalled
);
  localparam int BW_W = $clog2(ISSUE_W + 1);
  localparam logic [UOP_W-1:0] WIDE_U = UOP_W'(ISSUE_W);

  logic [UOP_W-1:0] carry_q, carry_d, carry_nx;
  logic             carry_eg_q, carry_eg_d;
  logic             held_q, held_d;
  logic [BW_W-1:0]  bw_c, used_c, bw_out, used_out;
  logic [CNT_W-1:0] stall_cnt, lwb_cnt, stall_amt;
  hazard_e          hz_kind;
  logic             held_wait, can_try, oversize, fits, bg_ok;
  logic             eligible, stall_now, issue;

  ioi_carry #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W)) u_carry (
    .carry_left(carry_q),
    .carry_eg  (carry_eg_q),
    .bw_after  (bw_c),
    .used      (used_c),
    .left_next (carry_nx)
  );

  ioi_hazard #(.CNT_W(CNT_W)) u_hazard (
    .reg_stall(in_reg_stall),
    .res_busy (in_res_busy),
    .ooo_ret  (in_ooo_ret),
    .wb_first (in_wb_first),
    .lwb_cur  (lwb_cnt),
    .stall_amt(stall_amt),
    .kind     (hz_kind)
  );

  ioi_downcnt #(.W(CNT_W)) u_stall_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (stall_now),
    .load_val(stall_amt),
    .cnt     (stall_cnt)
  );

  ioi_downcnt #(.W(CNT_W)) u_lwb_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (issue && !in_ooo_ret),
    .load_val(in_wb_last),
    .cnt     (lwb_cnt)
  );

  // Candidate qualification
  assign held_wait = held_q && (stall_cnt != '0);
  assign can_try   = in_valid && !held_wait && (carry_nx == '0);
  assign oversize  = in_uops > WIDE_U;
  assign fits      = oversize || (in_uops <= UOP_W'(bw_c));
  assign bg_ok     = !in_begin_grp || (used_c == '0);
  assign eligible  = can_try && fits && bg_ok;
  assign stall_now = eligible && (hz_kind != HZ_NONE);
  assign issue     = eligible && (hz_kind == HZ_NONE);

  // Slot bookkeeping for the rest of the cycle
  always_comb begin
    bw_out     = bw_c;
    used_out   = used_c;
    carry_d    = carry_nx;
    carry_eg_d = (carry_nx != '0) ? carry_eg_q : 1'b0;
    if (held_wait || stall_now)
      bw_out = '0;
    if (issue) begin
      if (in_uops > UOP_W'(bw_c)) begin
        carry_d    = in_uops - UOP_W'(bw_c);
        carry_eg_d = in_end_grp;
        used_out   = used_c + bw_c;
        bw_out     = '0;
      end else begin
        used_out = used_c + BW_W'(in_uops);
        bw_out   = in_end_grp ? '0 : bw_c - BW_W'(in_uops);
      end
    end
  end

  always_comb begin
    held_d = held_q;
    if (issue)
      held_d = 1'b0;
    else if (stall_now)
      held_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q    <= '0;
      carry_eg_q <= 1'b0;
      held_q     <= 1'b0;
    end else begin
      carry_q    <= carry_d;
      carry_eg_q <= carry_eg_d;
      held_q     <= held_d;
    end
  end

  assign in_ready    = issue;
  assign o_issue     = issue;
  assign o_bw_left   = bw_out;
  assign o_uops_used = used_out;
  assign o_stalled   = held_q;
endmodule

// File: rtl/ioi_issue_chk.sv
module ioi_issue_chk #(
  parameter int ISSUE_W = 4,
  parameter int UOP_W   = 4,
  parameter int CNT_W   = 5,
  localparam int BW_W   = $clog2(ISSUE_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             issue,
  input logic [UOP_W-1:0] uops,
  input logic             bg,
  input logic             eg,
  input logic [BW_W-1:0]  bw_left,
  input logic [BW_W-1:0]  used,
  input logic [BW_W-1:0]  carry_used,
  input logic             held,
  input logic [CNT_W-1:0] stall_cnt
);
  AST_USED_LE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    used <= BW_W'(ISSUE_W)); // R11
  AST_BIG_SPILL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    issue && (uops > UOP_W'(2 * ISSUE_W)) |=> !issue); // R3
  AST_BEGIN_GRP_FIRST: assert property (@(posedge clk) disable iff (rst)
    issue && bg |-> carry_used == '0); // R5
  AST_END_GRP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    issue && eg |-> bw_left == '0); // R6
  AST_HELD_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    held && (stall_cnt != '0) |-> !issue && (bw_left == '0)); // R10
  AST_HELD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    held && (stall_cnt != '0) |=> stall_cnt == CNT_W'($past(stall_cnt) - 1'b1)); // R10
endmodule

bind ioi_issue_ctrl ioi_issue_chk #(
  .ISSUE_W(ISSUE_W), .UOP_W(UOP_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue     (o_issue),
  .uops      (in_uops),
  .bg        (in_begin_grp),
  .eg        (in_end_grp),
  .bw_left   (o_bw_left),
  .used      (o_uops_used),
  .carry_used(used_c),
  .held      (held_q),
  .stall_cnt (stall_cnt)
);

// File: tb/ioi_issue_ctrl_test.sv
module ioi_issue_ctrl_test;
  localparam int ISSUE_W = 4;
  localparam int UOP_W   = 4;
  localparam int CNT_W   = 5;
  localparam int BW_W    = $clog2(ISSUE_W + 1);
  localparam int N_DIR   = 13;
  localparam int N_RAND  = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [UOP_W-1:0] in_uops = 4'd1;
  logic in_begin_grp = 1'b0, in_end_grp = 1'b0, in_ooo_ret = 1'b0;
  logic [CNT_W-1:0] in_wb_first = '0, in_wb_last = '0, in_reg_stall = '0;
  logic in_res_busy = 1'b0;
  logic o_issue, o_stalled;
  logic [BW_W-1:0] o_bw_left, o_uops_used;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Reference state
  int m_carry = 0, m_stall = 0, m_lwb = 0;
  bit m_ceg = 0, m_held = 0;
  int n_carry, n_stall, n_lwb;
  bit n_ceg, n_held;
  bit e_issue, e_held;
  int e_bw, e_used;
  string tag_iss, tag_bw;

  always #5 clk = ~clk;

  ioi_issue_ctrl #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_uops(in_uops), .in_begin_grp(in_begin_grp), .in_end_grp(in_end_grp),
    .in_ooo_ret(in_ooo_ret), .in_wb_first(in_wb_first), .in_wb_last(in_wb_last),
    .in_reg_stall(in_reg_stall), .in_res_busy(in_res_busy), .o_issue(o_issue),
    .o_bw_left(o_bw_left), .o_uops_used(o_uops_used), .o_stalled(o_stalled)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int dec0(int v);
    return (v > 0) ? v - 1 : 0;
  endfunction

  // Expected outputs and next state from the requirements
  task automatic model_eval();
    int bw, used, cnx, amt, kind, u;
    bit hw, fits, bgok, elig;
    u = int'(in_uops);
    if (m_carry == 0) begin bw = ISSUE_W; used = 0; cnx = 0; end
    else if (m_carry > ISSUE_W) begin bw = 0; used = ISSUE_W; cnx = m_carry - ISSUE_W; end
    else begin used = m_carry; bw = m_ceg ? 0 : ISSUE_W - m_carry; cnx = 0; end
    tag_bw = (m_carry != 0 && m_carry <= ISSUE_W && m_ceg) ? "R6" : "R2";
    hw   = m_held && (m_stall != 0);
    fits = (u > ISSUE_W) || (u <= bw);
    bgok = !in_begin_grp || (used == 0);
    elig = in_valid && !hw && (cnx == 0) && fits && bgok;
    if (in_reg_stall != 0) begin amt = int'(in_reg_stall); kind = 1; end
    else if (in_res_busy) begin amt = 1; kind = 2; end
    else if (!in_ooo_ret && m_lwb > int'(in_wb_first)) begin amt = m_lwb - int'(in_wb_first); kind = 3; end
    else begin amt = 0; kind = 0; end
    if (!in_valid) tag_iss = "R2";
    else if (hw) tag_iss = "R10";
    else if (cnx != 0) tag_iss = "R3";
    else if (!fits) tag_iss = "R4";
    else if (!bgok) tag_iss = "R5";
    else if (kind == 1 || kind == 2) tag_iss = "R7";
    else if (kind == 3) tag_iss = "R8";
    else if (u > ISSUE_W) tag_iss = "R3";
    else tag_iss = "R2";
    e_issue = elig && (kind == 0);
    n_ceg = (cnx != 0) ? m_ceg : 1'b0;
    n_carry = cnx;
    if (hw || (elig && kind != 0)) begin bw = 0; tag_bw = hw ? "R10" : "R7"; end
    if (e_issue) begin
      if (u > bw) begin n_carry = u - bw; n_ceg = in_end_grp; used += bw; bw = 0; end
      else begin used += u; bw = in_end_grp ? 0 : bw - u; if (in_end_grp) tag_bw = "R6"; end
    end
    e_bw = bw; e_used = used; e_held = m_held;
    n_held = e_issue ? 1'b0 : ((elig && kind != 0) ? 1'b1 : m_held);
    n_stall = (elig && kind != 0) ? dec0(amt) : dec0(m_stall);
    n_lwb = (e_issue && !in_ooo_ret) ? dec0(int'(in_wb_last)) : dec0(m_lwb);
  endtask

  // One cycle: inputs already driven after the falling edge
  task automatic step();
    #1;
    model_eval();
    chk(tag_iss, "issue", int'(o_issue), int'(e_issue));
    chk(tag_iss, "ready", int'(in_ready), int'(e_issue));
    chk(tag_bw, "bw_left", int'(o_bw_left), e_bw);
    chk("R11", "uops_used", int'(o_uops_used), e_used);
    chk("R10", "stalled", int'(o_stalled), int'(e_held));
    if (int'(o_uops_used) > ISSUE_W) chk("R11", "width cap", int'(o_uops_used), ISSUE_W);
    @(posedge clk);
    m_carry = n_carry; m_ceg = n_ceg; m_held = n_held; m_stall = n_stall; m_lwb = n_lwb;
    cyc++;
    @(negedge clk);
  endtask

  // Present one instruction until accepted; first-cycle hazards given,
  // later cycles random hazards when rnd is set. Returns acceptance cycle.
  task automatic offer(int u, bit bg, bit eg, bit ooo, int wf, int wl,
                       int rs, bit rb, bit rnd, output int at);
    bit first = 1;
    in_valid = 1; in_uops = UOP_W'(u); in_begin_grp = bg; in_end_grp = eg;
    in_ooo_ret = ooo; in_wb_first = CNT_W'(wf); in_wb_last = CNT_W'(wl);
    forever begin
      if (first) begin in_reg_stall = CNT_W'(rs); in_res_busy = rb; end
      else if (rnd) begin
        in_reg_stall = ($urandom_range(0, 9) == 0) ? CNT_W'($urandom_range(1, 3)) : '0;
        in_res_busy  = ($urandom_range(0, 9) == 0);
      end else begin in_reg_stall = '0; in_res_busy = 1'b0; end
      first = 0;
      #1;
      at = cyc;
      if (in_ready) begin step(); break; end
      step();
    end
    in_valid = 0; in_reg_stall = '0; in_res_busy = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int a8, a9, tmp;
    void'($urandom(32'h1D5C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state, idle input
    #1;
    chk("R1", "ready", int'(in_ready), 0);
    chk("R1", "bw_left", int'(o_bw_left), ISSUE_W);
    chk("R1", "uops_used", int'(o_uops_used), 0);
    chk("R1", "stalled", int'(o_stalled), 0);
    step();
    // Directed corner cases
    offer(7, 0, 0, 0, 0, 0, 0, 0, 0, tmp);   // R3 spill of 3
    offer(2, 0, 0, 0, 0, 0, 0, 0, 0, tmp);   // R4 only 1 slot in completion cycle
    offer(6, 0, 1, 0, 0, 0, 0, 0, 0, tmp);   // R6 spill ends with end-group
    offer(1, 0, 0, 0, 0, 0, 0, 0, 0, tmp);   // R6 blocked by closed slots
    offer(5, 0, 0, 0, 0, 0, 0, 0, 0, tmp);   // R3 spill of 1
    offer(1, 1, 0, 0, 0, 0, 0, 0, 0, tmp);   // R5 begin-group after carry
    offer(2, 0, 0, 0, 0, 0, 3, 1, 0, tmp);   // R7 register count wins over busy
    offer(1, 0, 0, 0, 0, 0, 0, 1, 0, tmp);   // R7 busy stalls one cycle
    offer(1, 0, 0, 0, 0, 6, 0, 0, 0, a8);    // R9 writer with latest delay 6
    offer(1, 0, 0, 0, 0, 2, 0, 0, 0, a9);    // R8 ordered follower
    chk("R9", "last write-back delay", a9 - a8, 6);
    offer(1, 0, 0, 0, 0, 6, 0, 0, 0, tmp);
    offer(1, 0, 0, 1, 0, 0, 0, 0, 0, a9);    // R8 out-of-order retire exempt
    chk("R8", "no wait when exempt", a9 - tmp, 1);
    offer(12, 0, 0, 0, 0, 0, 0, 0, 0, tmp);  // R3 long spill
    // Random traffic
    for (int i = 0; i < N_RAND; i++) begin
      int u, wf;
      if ($urandom_range(0, 4) == 0) step();
      u  = $urandom_range(1, 7);
      wf = $urandom_range(0, 6);
      offer(u, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0),
            ($urandom_range(0, 4) == 0), wf, wf + $urandom_range(0, 4),
            ($urandom_range(0, 7) == 0) ? $urandom_range(1, 3) : 0,
            ($urandom_range(0, 7) == 0), 1, tmp);
    end
    repeat (4) step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule